// File: doc/BRIEF.md
# Direct-Mapped Wide-Line Cache with Single-Transfer Fill

This block is a cache level between a processor-side cache and a slow backing memory whose word is very wide. The processor port is narrow: it reads or writes one bus word per request. The backing port is wide: it moves one complete line per transaction. Each stored line is exactly one backing-memory word. Because of this, a miss is served by at most two long transfers, an optional write-back and then a fetch, and never by a burst of beats.

Storage is organised as columns of bus words. The line index of the address selects a column. The offset selects one word inside that column for the narrow port. The backing port always reads or writes the whole column at once. Placement is direct mapped, so the cost is one tag compare and a hit answers in the same cycle as the request. Each line carries a valid bit and a dirty bit.

The controller has three states:
- LOOKUP: idle, and hit service.
- WRITEBACK: the dirty victim is sent out.
- FETCH: the new line is brought in.

The transitions are:
- LOOKUP to WRITEBACK, on a miss whose victim is valid and dirty.
- LOOKUP to FETCH, on a miss whose victim is clean or invalid.
- WRITEBACK to FETCH, on acknowledge.
- FETCH to LOOKUP, on acknowledge.

Back in LOOKUP, the held request hits in the freshly written line and completes there.

Top module: `wlc_top`

## Requirements
- R1: After reset every line is invalid. With no request, `cpu_ready` and `mem_req` are low, and the first access to any address is a miss.
- R2: The word address `cpu_addr` splits as follows: bits [OFF_W-1:0] are the word offset, the next IDX_W bits are the line index, and the remaining top bits are the tag. A fetch uses line address `cpu_addr >> OFF_W`.
- R3: A read that hits raises `cpu_ready` in the cycle the request is presented, with `cpu_rdata` equal to the word at the offset.
- R4: A write that hits changes only the addressed word. The other words of the line keep their values.
- R5: On a miss, `cpu_ready` stays low while the backing transfers are outstanding. Exactly one line read is issued for the missing line. The stalled request then completes with no further backing transaction.
- R6: A processor write marks its line dirty. A dirty victim is written back as one full-line transfer (`mem_we`=1, address `{victim tag, index}`, data = the current line) before the fetch. The fetch follows immediately.
- R7: A clean or invalid victim causes no write-back, only the fetch.
- R8: `mem_req` stays high with stable `mem_addr` and `mem_we` until `mem_ack`. Only one transaction is outstanding at a time.
- R9: `cpu_ready` is never high while `cpu_req` is low.
- R10: A write miss fetches the line, then merges the written word into it and leaves the line dirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | WORD_W | Write word |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | WORD_W | Read word, valid with `cpu_ready` |
| mem_req | output | 1 | Backing transaction request |
| mem_we | output | 1 | 1 = line write-back, 0 = line fetch |
| mem_addr | output | ADDR_W-OFF_W | Line address |
| mem_wdata | output | WORD_W*LINE_WORDS | Full line written back |
| mem_ack | input | 1 | One-cycle completion strobe |
| mem_rdata | input | WORD_W*LINE_WORDS | Full line returned on `mem_ack` |

## Verification
The assertions check the backing handshake on every cycle: the request is held, its address and direction are stable, and a fetch follows right after a write-back acknowledge. They also check that the processor is stalled whenever a backing transfer is pending, and that `cpu_ready` appears only under a request. The bench scenarios show the rest. Those are the hit or miss outcome of each address sequence, the merged word values, the victim address and line contents on write-back, and the absence of a write-back for clean victims. All of these are predicted by a reference tag model and a flat word memory in the bench.

// File: rtl/wlc_pkg.sv
package wlc_pkg;
    typedef enum logic [1:0] {
        ST_LOOKUP    = 2'd0,
        ST_WRITEBACK = 2'd1,
        ST_FETCH     = 2'd2
    } wlc_state_e;
endpackage

// File: rtl/wlc_tags.sv
module wlc_tags #(
    parameter int LINES = 16,
    parameter int TAG_W = 3,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag_in,
    input  logic             fill_en,
    input  logic             dirty_set,
    output logic             hit,
    output logic             vic_valid,
    output logic             vic_dirty,
    output logic [TAG_W-1:0] vic_tag
);
    logic [TAG_W-1:0] tag_mem [LINES];
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (dirty_set) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) tag_mem[idx] <= tag_in;
    end

    assign vic_valid = valid_q[idx];
    assign vic_dirty = dirty_q[idx];
    assign vic_tag   = tag_mem[idx];
    assign hit       = valid_q[idx] && (tag_mem[idx] == tag_in);
endmodule

// File: rtl/wlc_array.sv
module wlc_array #(
    parameter int LINES      = 16,
    parameter int LINE_WORDS = 8,
    parameter int WORD_W     = 32,
    localparam int IDX_W  = $clog2(LINES),
    localparam int OFF_W  = $clog2(LINE_WORDS),
    localparam int LINE_W = WORD_W * LINE_WORDS
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  col,
    input  logic [OFF_W-1:0]  off,
    input  logic              line_we,
    input  logic [LINE_W-1:0] line_wdata,
    input  logic              word_we,
    input  logic [WORD_W-1:0] word_wdata,
    output logic [LINE_W-1:0] line_rdata,
    output logic [WORD_W-1:0] word_rdata
);
    logic [LINE_W-1:0] cols [LINES];
    logic [LINE_W-1:0] merged;
    logic [WORD_W-1:0] words [LINE_WORDS];

    assign line_rdata = cols[col];

    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
        assign words[w] = line_rdata[w*WORD_W +: WORD_W];
        assign merged[w*WORD_W +: WORD_W] =
            (off == OFF_W'(w)) ? word_wdata : line_rdata[w*WORD_W +: WORD_W];
    end

    assign word_rdata = words[off];

    always_ff @(posedge clk) begin
        if (line_we)      cols[col] <= line_wdata;
        else if (word_we) cols[col] <= merged;
    end
endmodule

// File: rtl/wlc_ctrl.sv
module wlc_ctrl
    import wlc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic cpu_we,
    input  logic hit,
    input  logic vic_valid,
    input  logic vic_dirty,
    input  logic mem_ack,
    output logic cpu_ready,
    output logic word_we,
    output logic dirty_set,
    output logic fill_en,
    output logic mem_req,
    output logic mem_we,
    output logic wb_sel
);
    wlc_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOOKUP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOOKUP: begin
                if (cpu_req && !hit)
                    state_d = (vic_valid && vic_dirty) ? ST_WRITEBACK : ST_FETCH;
            end
            ST_WRITEBACK: if (mem_ack) state_d = ST_FETCH;
            ST_FETCH:     if (mem_ack) state_d = ST_LOOKUP;
            default:      state_d = ST_LOOKUP;
        endcase
    end

    always_comb begin
        cpu_ready = 1'b0;
        word_we   = 1'b0;
        dirty_set = 1'b0;
        fill_en   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        wb_sel    = 1'b0;
        unique case (state_q)
            ST_LOOKUP: begin
                cpu_ready = cpu_req && hit;
                word_we   = cpu_req && hit && cpu_we;
                dirty_set = cpu_req && hit && cpu_we;
            end
            ST_WRITEBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                wb_sel  = 1'b1;
            end
            ST_FETCH: begin
                mem_req = 1'b1;
                fill_en = mem_ack;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/wlc_top.sv
module wlc_top #(
    parameter int ADDR_W     = 10,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 8,
    parameter int LINES      = 16,
    localparam int OFF_W   = $clog2(LINE_WORDS),
    localparam int IDX_W   = $clog2(LINES),
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
    localparam int LADDR_W = ADDR_W - OFF_W,
    localparam int LINE_W  = WORD_W * LINE_WORDS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [WORD_W-1:0]  cpu_wdata,
    output logic               cpu_ready,
    output logic [WORD_W-1:0]  cpu_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [LADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0]  mem_wdata,
    input  logic               mem_ack,
    input  logic [LINE_W-1:0]  mem_rdata
);
    logic [OFF_W-1:0] off;
    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    logic             hit, vic_valid, vic_dirty;
    logic [TAG_W-1:0] vic_tag;
    logic             word_we, dirty_set, fill_en, wb_sel;

    assign off = cpu_addr[OFF_W-1:0];
    assign idx = cpu_addr[OFF_W +: IDX_W];
    assign tag = cpu_addr[ADDR_W-1 -: TAG_W];

    wlc_tags #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .idx(idx), .tag_in(tag),
        .fill_en(fill_en), .dirty_set(dirty_set), .hit(hit),
        .vic_valid(vic_valid), .vic_dirty(vic_dirty), .vic_tag(vic_tag)
    );

    wlc_array #(.LINES(LINES), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)) u_array (
        .clk(clk), .col(idx), .off(off),
        .line_we(fill_en), .line_wdata(mem_rdata),
        .word_we(word_we), .word_wdata(cpu_wdata),
        .line_rdata(mem_wdata), .word_rdata(cpu_rdata)
    );

    wlc_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .hit(hit), .vic_valid(vic_valid), .vic_dirty(vic_dirty),
        .mem_ack(mem_ack), .cpu_ready(cpu_ready), .word_we(word_we),
        .dirty_set(dirty_set), .fill_en(fill_en), .mem_req(mem_req),
        .mem_we(mem_we), .wb_sel(wb_sel)
    );

    assign mem_addr = wb_sel ? {vic_tag, idx} : {tag, idx};
endmodule

// File: rtl/wlc_checker.sv
module wlc_checker #(
    parameter int ADDR_W     = 10,
    parameter int LINE_WORDS = 8,
    localparam int LADDR_W = ADDR_W - $clog2(LINE_WORDS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cpu_req,
    input logic               cpu_ready,
    input logic               mem_req,
    input logic               mem_we,
    input logic               mem_ack,
    input logic [LADDR_W-1:0] mem_addr
);
    // R5: processor stalled while a backing transfer is pending
    a_r5_stall_during_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);

    // R8: request held with stable address and direction until acknowledged
    a_r8_req_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R8: an acknowledge only answers a live request
    a_r8_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ack |-> mem_req);

    // R6: a completed write-back is followed at once by a fetch
    a_r6_fetch_after_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

    // R9: no completion without a request
    a_r9_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_req);
endmodule

bind wlc_top wlc_checker #(.ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr)
);

// File: tb/wlc_top_test.sv
module wlc_top_test;
    localparam int ADDR_W = 10, WORD_W = 32, LINE_WORDS = 8, LINES = 16;
    localparam int OFF_W = 3, IDX_W = 4, TAG_W = ADDR_W - OFF_W - IDX_W;
    localparam int LADDR_W = ADDR_W - OFF_W, LINE_W = WORD_W * LINE_WORDS;
    localparam int LAT = 100;
    localparam int NLINES = 1 << LADDR_W;
    localparam int NWORDS = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [WORD_W-1:0] cpu_wdata = '0;
    logic cpu_ready;
    logic [WORD_W-1:0] cpu_rdata;
    logic mem_req, mem_we;
    logic [LADDR_W-1:0] mem_addr;
    logic [LINE_W-1:0] mem_wdata;
    logic mem_ack;
    logic [LINE_W-1:0] mem_rdata;

    always #10 clk = ~clk;

    wlc_top #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .LINES(LINES)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    // Backing memory: fixed-latency wide-word responder
    logic [LINE_W-1:0] bmem [NLINES];
    int cnt, n_rd, n_wr, hs_err;
    logic [LADDR_W-1:0] req_addr, wb_addr, rd_addr;
    logic req_we;
    logic [LINE_W-1:0] wb_data;

    function automatic logic [WORD_W-1:0] init_word(int a);
        return WORD_W'(a) * 32'h9E3779B1 ^ 32'h5A5A0000;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0; cnt <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0; cnt <= 0;
        end else if (mem_req) begin
            if (cnt == 0) begin req_addr <= mem_addr; req_we <= mem_we; end
            else if (mem_addr != req_addr || mem_we != req_we) hs_err <= hs_err + 1;
            if (cnt == LAT - 1) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    bmem[mem_addr] <= mem_wdata; n_wr <= n_wr + 1;
                    wb_addr <= mem_addr; wb_data <= mem_wdata;
                end else begin
                    mem_rdata <= bmem[mem_addr]; n_rd <= n_rd + 1; rd_addr <= mem_addr;
                end
            end
            cnt <= cnt + 1;
        end
    end

    // Reference model
    logic [WORD_W-1:0] gmem [NWORDS];
    logic [TAG_W-1:0] mtag [LINES];
    logic [LINES-1:0] mvalid = '0, mdirty = '0;
    int checks = 0, errors = 0;

    function automatic logic [LINE_W-1:0] gline(logic [LADDR_W-1:0] la);
        logic [LINE_W-1:0] l;
        for (int w = 0; w < LINE_WORDS; w++) l[w*WORD_W +: WORD_W] = gmem[{la, OFF_W'(w)}];
        return l;
    endfunction

    task automatic check(bit ok, string req, logic [LINE_W-1:0] act, logic [LINE_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(bit we, logic [ADDR_W-1:0] a, logic [WORD_W-1:0] d);
        logic [IDX_W-1:0] ix = a[OFF_W +: IDX_W];
        logic [TAG_W-1:0] tg = a[ADDR_W-1 -: TAG_W];
        bit exp_hit = mvalid[ix] && (mtag[ix] == tg);
        bit exp_wb = !exp_hit && mvalid[ix] && mdirty[ix];
        logic [LADDR_W-1:0] vic_la = {mtag[ix], ix};
        logic [LINE_W-1:0] vic_line = gline(vic_la);
        logic [WORD_W-1:0] exp_rd = gmem[a];
        int rd0 = n_rd, wr0 = n_wr, stall = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        #1;
        while (!cpu_ready) begin
            @(negedge clk); #1; stall++;
        end
        if (!we) check(cpu_rdata == exp_rd, "R3/R4/R10 read data", LINE_W'(cpu_rdata), LINE_W'(exp_rd));
        check((stall == 0) == exp_hit, "R3/R5 hit vs stall", LINE_W'(stall), LINE_W'(!exp_hit));
        check(n_rd - rd0 == (exp_hit ? 0 : 1), "R5/R7 line fetch count", LINE_W'(n_rd - rd0), LINE_W'(!exp_hit));
        check(n_wr - wr0 == (exp_wb ? 1 : 0), "R6/R7 write-back count", LINE_W'(n_wr - wr0), LINE_W'(exp_wb));
        if (!exp_hit) check(rd_addr == a[ADDR_W-1:OFF_W], "R2 fetch line address", LINE_W'(rd_addr), LINE_W'(a[ADDR_W-1:OFF_W]));
        if (exp_wb) begin
            check(wb_addr == vic_la, "R6 victim address", LINE_W'(wb_addr), LINE_W'(vic_la));
            check(wb_data == vic_line, "R6 victim line", wb_data, vic_line);
        end
        if (!exp_hit) begin mtag[ix] = tg; mvalid[ix] = 1'b1; mdirty[ix] = 1'b0; end
        if (we) begin mdirty[ix] = 1'b1; gmem[a] = d; end
        @(posedge clk);
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic run_tests();
        for (int i = 0; i < NWORDS; i++) gmem[i] = init_word(i);
        for (int l = 0; l < NLINES; l++) bmem[l] = gline(LADDR_W'(l));
        n_rd = 0; n_wr = 0; hs_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check(!cpu_ready && !mem_req, "R1 reset idle outputs", LINE_W'({cpu_ready, mem_req}), '0);
        // R1/R5: first access misses with a clean fill
        access(1'b0, 10'h005, '0);
        // R3: other offsets of the same line hit
        access(1'b0, 10'h003, '0);
        access(1'b0, 10'h007, '0);
        // R4: write hit changes only its word
        access(1'b1, 10'h002, 32'hDEADBEEF);
        access(1'b0, 10'h002, '0);
        access(1'b0, 10'h001, '0);
        access(1'b0, 10'h003, '0);
        // R6: conflicting tag evicts the dirty line
        access(1'b0, 10'h085, '0);
        // R7: clean victim, then R6 contents observed after refetch
        access(1'b0, 10'h002, '0);
        // R10: write miss merges and leaves line dirty
        access(1'b1, 10'h204, 32'h12345678);
        access(1'b0, 10'h204, '0);
        access(1'b0, 10'h284, '0);
        access(1'b0, 10'h204, '0);
        // R9: idle request yields no ready
        #1;
        check(!cpu_ready, "R9 ready without request", LINE_W'(cpu_ready), '0);
        // constrained random mix
        for (int i = 0; i < 250; i++) begin
            logic [ADDR_W-1:0] a;
            if ($urandom % 8 == 0) a = ADDR_W'($urandom % NWORDS);
            else a = ADDR_W'((($urandom % 2) << (OFF_W + IDX_W)) | ($urandom % 128));
            access(($urandom % 3) == 0, a, $urandom);
        end
        check(hs_err == 0, "R8 handshake stability", LINE_W'(hs_err), '0);
    endtask

    initial begin
        bit timed_out = 1'b0;
        void'($urandom(32'd20240611));
        fork
            run_tests();
            begin repeat (190000) @(posedge clk); timed_out = 1'b1; end
        join_any
        if (timed_out) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule